// File: doc/BRIEF.md
# Seconds counter with countdown alarm

This block keeps time in whole seconds. It is driven by a strobe, `ref_tick`, that pulses once for each edge of a 32.768 kHz reference, so there are two strobes per reference period. A prescaler counts these strobes. Taps of the prescaler give square waves at 32.768 kHz, 8192 Hz, 4096 Hz and 1 Hz. When the prescaler wraps, it produces a one-second tick. That tick advances a free-running binary seconds counter. The same tick also steps a countdown alarm, which reloads itself each time it expires.

One output, `pin_n`, is an active-low pull-down request for a shared open-drain pin. One control bit decides what drives it: either the selected square wave, or the alarm flag gated by the alarm enable. Software reaches four registers through a parallel write strobe and a combinational read select.

The alarm is run by a three-state machine:
- **ALM_IDLE** holds the count. It moves to **ALM_COUNT** when the alarm is enabled, the reload value is non-zero and no load is in progress.
- **ALM_COUNT** decrements on each second tick. It moves to **ALM_FIRE** on the tick that takes the count from 1 to 0. It falls back to **ALM_IDLE** on a load or when the alarm is disabled.
- **ALM_FIRE** lasts one cycle. It reloads the count and sets the flag if the alarm is enabled. It then returns to **ALM_COUNT**, or to **ALM_IDLE** on a load or when the alarm is disabled.

Top module: `secctr_core`

## Requirements
- R1: After reset, the registers read as follows. Seconds and alarm count are 0. Control reads 0x04. Status reads 0x2 (OSF=1, AF=0). `pin_n` is 1.
- R2: While running, the seconds counter rises by exactly 1 once every 2^DIV_W strobes of `ref_tick`. It does not change on cycles without a strobe.
- R3: A write to the seconds register (select 0) loads the value and clears the prescaler. The next increment comes exactly 2^DIV_W strobes after the write.
- R4: While control bit 4 (oscillator off) is 1, the following hold their values: the prescaler, the seconds counter and the alarm count. The status bit 1 (OSF) is also set.
- R5: Status flags are cleared only by writing 0 to their bit at select 3. Writing 1 has no effect. OSF cannot be cleared while the oscillator is off.
- R6: With control bit 3 (alarm enable) set and a non-zero value written at select 1, the alarm count drops by 1 on each second tick. The cycle after it reaches 0, AF (status bit 0) sets and the count reloads the written value. This repeats every reload-value seconds.
- R7: With the alarm enable clear, the alarm count holds and AF is never set.
- R8: With control bit 2 (interrupt mode) set, `pin_n` is 0 exactly when AF and the alarm enable are both 1.
- R9: With control bit 2 clear, `pin_n` equals a prescaler bit chosen by control bits [1:0]. The choices are: 00 selects bit DIV_W-1 (1 Hz), 01 selects bit 3 (4096 Hz), 10 selects bit 2 (8192 Hz) and 11 selects bit 0 (32.768 kHz).
- R10: The seconds counter wraps from all ones to 0.
- R11: A reload value of 0 never fires the alarm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One strobe per reference clock edge (2 x 32.768 kHz) |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write select: 0 seconds, 1 alarm, 2 control, 3 status |
| wr_data | input | CNT_W | Write data |
| rd_sel | input | 2 | Read select, same encoding as wr_sel |
| rd_data | output | CNT_W | Read data (alarm reads current count) |
| pin_n | output | 1 | 0 requests the shared pin be pulled low |

## Verification
The bench targets the alarm's expiry timing and its repeat.
- A design that reloads too early, or that sets the flag in the wrong cycle, shows a non-zero count or a clear flag in the cycle just after the last tick.
- A design that counts from the reload instead of the programmed value fires late on the second period.

The bench also probes three more cases:
- **Prescaler clear on a seconds write.** It samples one strobe before and one strobe after the second boundary, so an uncleared divider shows up as an early tick.
- **Hold and flag behaviour while stopped.** It checks that nothing counts while the oscillator is off and that OSF cannot be cleared then.
- **Tap choice for each rate code.** It checks the tap positions of the square-wave mux at several prescaler values.

// File: rtl/secctr_pkg.sv
package secctr_pkg;

    typedef enum logic [1:0] {
        ALM_IDLE  = 2'd0,
        ALM_COUNT = 2'd1,
        ALM_FIRE  = 2'd2
    } alm_state_e;

    typedef enum logic [1:0] {
        SEL_SECS  = 2'd0,
        SEL_ALARM = 2'd1,
        SEL_CTRL  = 2'd2,
        SEL_STAT  = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        RATE_1HZ  = 2'd0,
        RATE_4K   = 2'd1,
        RATE_8K   = 2'd2,
        RATE_32K  = 2'd3
    } rate_e;

    typedef struct packed {
        logic  osc_off;
        logic  alm_en;
        logic  irq_mode;
        rate_e rate;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/secctr_prescale.sv
module secctr_prescale
    import secctr_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       ref_tick,
    input  logic       clear,
    input  rate_e      rate,
    output logic       sec_tick,
    output logic       wave
);

    logic [DIV_W-1:0] div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (clear) begin
            div_q <= '0;
        end else if (run && ref_tick) begin
            div_q <= div_q + 1'b1;
        end
    end

    assign sec_tick = run && ref_tick && !clear && (&div_q);

    always_comb begin
        unique case (rate)
            RATE_1HZ: wave = div_q[DIV_W-1];
            RATE_4K:  wave = div_q[3];
            RATE_8K:  wave = div_q[2];
            RATE_32K: wave = div_q[0];
            default:  wave = 1'b1;
        endcase
    end

endmodule

// File: rtl/secctr_alarm.sv
module secctr_alarm
    import secctr_pkg::*;
#(
    parameter int ALM_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sec_tick,
    input  logic             enable,
    input  logic             load,
    input  logic [ALM_W-1:0] load_val,
    input  logic             flag_clr,
    output logic [ALM_W-1:0] count,
    output logic [ALM_W-1:0] reload,
    output logic             flag
);

    alm_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ALM_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ALM_IDLE: begin
                if (!load && enable && (reload != '0)) state_d = ALM_COUNT;
            end
            ALM_COUNT: begin
                if (load || !enable)                            state_d = ALM_IDLE;
                else if (sec_tick && (count == ALM_W'(1)))      state_d = ALM_FIRE;
            end
            ALM_FIRE: begin
                if (load || !enable) state_d = ALM_IDLE;
                else                 state_d = ALM_COUNT;
            end
            default: state_d = ALM_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count  <= '0;
            reload <= '0;
            flag   <= 1'b0;
        end else begin
            if (load) begin
                reload <= load_val;
                count  <= load_val;
            end else if (state_q == ALM_COUNT && enable && sec_tick) begin
                count <= count - 1'b1;
            end else if (state_q == ALM_FIRE) begin
                count <= reload;
            end

            if (state_q == ALM_FIRE && enable) flag <= 1'b1;
            else if (flag_clr)                 flag <= 1'b0;
        end
    end

endmodule

// File: rtl/secctr_core.sv
module secctr_core
    import secctr_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int ALM_W = 24,
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_tick,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       rd_sel,
    output logic [CNT_W-1:0] rd_data,
    output logic             pin_n
);

    reg_sel_e         wsel, rsel;
    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] sec_q;
    logic             osf_q;
    logic             sec_tick, wave;
    logic             wr_secs, wr_alarm, wr_ctrl, wr_stat;
    logic [ALM_W-1:0] alm_count, alm_reload;
    logic             alm_flag;
    logic             osc_off, alm_en, irq_mode;

    assign wsel     = reg_sel_e'(wr_sel);
    assign rsel     = reg_sel_e'(rd_sel);
    assign wr_secs  = wr_en && (wsel == SEL_SECS);
    assign wr_alarm = wr_en && (wsel == SEL_ALARM);
    assign wr_ctrl  = wr_en && (wsel == SEL_CTRL);
    assign wr_stat  = wr_en && (wsel == SEL_STAT);

    assign osc_off  = ctrl_q.osc_off;
    assign alm_en   = ctrl_q.alm_en;
    assign irq_mode = ctrl_q.irq_mode;

    secctr_prescale #(.DIV_W(DIV_W)) u_prescale (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (!osc_off),
        .ref_tick (ref_tick),
        .clear    (wr_secs),
        .rate     (ctrl_q.rate),
        .sec_tick (sec_tick),
        .wave     (wave)
    );

    secctr_alarm #(.ALM_W(ALM_W)) u_alarm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sec_tick (sec_tick),
        .enable   (alm_en),
        .load     (wr_alarm),
        .load_val (wr_data[ALM_W-1:0]),
        .flag_clr (wr_stat && !wr_data[0]),
        .count    (alm_count),
        .reload   (alm_reload),
        .flag     (alm_flag)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '{osc_off: 1'b0, alm_en: 1'b0, irq_mode: 1'b1, rate: RATE_1HZ};
        end else if (wr_ctrl) begin
            ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        sec_q <= '0;
        else if (wr_secs)  sec_q <= wr_data;
        else if (sec_tick) sec_q <= sec_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     osf_q <= 1'b1;
        else if (osc_off)               osf_q <= 1'b1;
        else if (wr_stat && !wr_data[1]) osf_q <= 1'b0;
    end

    always_comb begin
        unique case (rsel)
            SEL_SECS:  rd_data = sec_q;
            SEL_ALARM: rd_data = CNT_W'(alm_count);
            SEL_CTRL:  rd_data = CNT_W'(ctrl_q);
            SEL_STAT:  rd_data = CNT_W'({osf_q, alm_flag});
            default:   rd_data = '0;
        endcase
    end

    assign pin_n = irq_mode ? !(alm_flag && alm_en) : wave;

endmodule

// File: rtl/secctr_core_chk.sv
module secctr_core_chk #(
    parameter int CNT_W = 32,
    parameter int ALM_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             wr_secs,
    input logic             osc_off,
    input logic             alm_en,
    input logic             irq_mode,
    input logic [CNT_W-1:0] sec_q,
    input logic [ALM_W-1:0] alm_count,
    input logic [ALM_W-1:0] alm_reload,
    input logic             alm_flag,
    input logic             osf_q,
    input logic             pin_n
);

    logic [CNT_W-1:0] sec_prev;
    logic             prev_wr;
    logic             prev_ok;
    logic [CNT_W-1:0] sec_delta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sec_prev <= '0;
            prev_wr  <= 1'b0;
            prev_ok  <= 1'b0;
        end else begin
            sec_prev <= sec_q;
            prev_wr  <= wr_secs;
            prev_ok  <= 1'b1;
        end
    end

    assign sec_delta = sec_q - sec_prev;

    // R2: without a load the counter never moves by more than one step
    p_sec_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_ok && !prev_wr) |-> (sec_delta <= CNT_W'(1)));

    // R4: a stopped oscillator freezes the seconds counter
    p_hold_stopped_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_off && !wr_secs) |=> $stable(sec_q));

    // R4: a stopped oscillator marks OSF
    p_osf_stopped_r4: assert property (@(posedge clk) disable iff (!rst_n)
        osc_off |=> osf_q);

    // R5: AF is sticky without a register write
    p_af_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (alm_flag && !wr_en) |=> alm_flag);

    // R6: the flag rises together with a reload of a non-zero value
    p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alm_flag) |-> ((alm_count == alm_reload) && (alm_reload != '0)));

    // R7: a disabled alarm cannot raise the flag
    p_alarm_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!alm_en && !alm_flag) |=> !alm_flag);

    // R8: in interrupt mode a clear flag leaves the pin released
    p_pin_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_mode && !alm_flag) |-> pin_n);

endmodule

bind secctr_core secctr_core_chk #(.CNT_W(CNT_W), .ALM_W(ALM_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_secs    (wr_secs),
    .osc_off    (osc_off),
    .alm_en     (alm_en),
    .irq_mode   (irq_mode),
    .sec_q      (sec_q),
    .alm_count  (alm_count),
    .alm_reload (alm_reload),
    .alm_flag   (alm_flag),
    .osf_q      (osf_q),
    .pin_n      (pin_n)
);

// File: tb/secctr_core_test.sv
`timescale 1ns/1ps
module secctr_core_test;

    localparam int DIV_W = 6;
    localparam int SEC   = 1 << DIV_W;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_sel = 2'd0;
    logic [31:0] rd_data;
    logic        pin_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    secctr_core #(.CNT_W(32), .ALM_W(24), .DIV_W(DIV_W)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_tick (ref_tick),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .rd_sel   (rd_sel),
        .rd_data  (rd_data),
        .pin_n    (pin_n)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] sel, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [1:0] sel, output logic [31:0] d);
        rd_sel = sel;
        #1;
        d = rd_data;
    endtask

    task automatic strobe(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ref_tick = 1'b1;
        end
        @(negedge clk);
        ref_tick = 1'b0;
    endtask

    function automatic logic tap(int r, int pos);
        int p = pos % SEC;
        case (r)
            0:       return p[DIV_W-1];
            1:       return p[3];
            2:       return p[2];
            default: return p[0];
        endcase
    endfunction

    task automatic t_reset();
        logic [31:0] d;
        rd(2'd0, d); chk("R1", "seconds", d, 32'd0);
        rd(2'd1, d); chk("R1", "alarm", d, 32'd0);
        rd(2'd2, d); chk("R1", "control", d, 32'h04);
        rd(2'd3, d); chk("R1", "status", d, 32'h2);
        chk("R1", "pin_n", {31'd0, pin_n}, 32'd1);
    endtask

    task automatic t_count();
        logic [31:0] d;
        wr(2'd3, 32'h0);
        rd(2'd3, d); chk("R5", "OSF cleared by 0", d, 32'h0);
        wr(2'd3, 32'h3);
        rd(2'd3, d); chk("R5", "writing 1 sets nothing", d, 32'h0);
        wr(2'd0, 32'd100);
        strobe(SEC - 1);
        rd(2'd0, d); chk("R3", "no tick before full second", d, 32'd100);
        strobe(1);
        rd(2'd0, d); chk("R3", "tick at full second", d, 32'd101);
        strobe(SEC);
        rd(2'd0, d); chk("R2", "second increment", d, 32'd102);
        repeat (20) @(negedge clk);
        rd(2'd0, d); chk("R2", "no strobe no count", d, 32'd102);
    endtask

    task automatic t_wrap();
        logic [31:0] d;
        wr(2'd0, 32'hFFFF_FFFF);
        strobe(SEC);
        rd(2'd0, d); chk("R10", "wrap to zero", d, 32'd0);
    endtask

    task automatic t_alarm();
        logic [31:0] d;
        wr(2'd2, 32'h0C);
        wr(2'd0, 32'd0);
        wr(2'd1, 32'd3);
        strobe(SEC);
        rd(2'd1, d); chk("R6", "count after 1 s", d, 32'd2);
        strobe(SEC);
        rd(2'd1, d); chk("R6", "count after 2 s", d, 32'd1);
        strobe(SEC);
        rd(2'd1, d); chk("R6", "count reaches zero", d, 32'd0);
        rd(2'd3, d); chk("R6", "AF not yet set", d, 32'd0);
        @(negedge clk);
        rd(2'd3, d); chk("R6", "AF set", d, 32'd1);
        rd(2'd1, d); chk("R6", "reloaded", d, 32'd3);
        chk("R8", "pin low on AF", {31'd0, pin_n}, 32'd0);
        wr(2'd3, 32'h2);
        rd(2'd3, d); chk("R5", "AF cleared", d, 32'd0);
        chk("R8", "pin released", {31'd0, pin_n}, 32'd1);
        strobe(3 * SEC - 1);
        rd(2'd1, d); chk("R6", "second period count", d, 32'd1);
        rd(2'd3, d); chk("R6", "no early fire", d, 32'd0);
        strobe(1);
        @(negedge clk);
        rd(2'd3, d); chk("R6", "repeat fire", d, 32'd1);
        rd(2'd1, d); chk("R6", "repeat reload", d, 32'd3);
    endtask

    task automatic t_alarm_off();
        logic [31:0] d;
        wr(2'd2, 32'h04);
        chk("R8", "AF gated by enable", {31'd0, pin_n}, 32'd1);
        rd(2'd3, d); chk("R5", "AF sticky", d, 32'd1);
        strobe(4 * SEC);
        rd(2'd1, d); chk("R7", "count held", d, 32'd3);
        wr(2'd3, 32'h2);
        strobe(4 * SEC);
        rd(2'd3, d); chk("R7", "AF stays clear", d, 32'd0);
    endtask

    task automatic t_zero_reload();
        logic [31:0] d;
        wr(2'd2, 32'h0C);
        wr(2'd1, 32'd0);
        strobe(2 * SEC + 2);
        rd(2'd3, d); chk("R11", "no fire", d, 32'd0);
        rd(2'd1, d); chk("R11", "count zero", d, 32'd0);
    endtask

    task automatic t_stop();
        logic [31:0] d;
        wr(2'd2, 32'h0C);
        wr(2'd1, 32'd5);
        wr(2'd0, 32'd7);
        wr(2'd2, 32'h1C);
        strobe(200);
        rd(2'd0, d); chk("R4", "seconds held", d, 32'd7);
        rd(2'd1, d); chk("R4", "alarm held", d, 32'd5);
        rd(2'd3, d); chk("R4", "OSF set", d, 32'h2);
        wr(2'd3, 32'h0);
        rd(2'd3, d); chk("R5", "OSF kept while stopped", d, 32'h2);
        wr(2'd2, 32'h04);
        wr(2'd3, 32'h0);
        rd(2'd3, d); chk("R5", "OSF cleared when running", d, 32'h0);
    endtask

    task automatic t_wave();
        int steps[6] = '{1, 3, 4, 8, 16, 1};
        for (int r = 0; r < 4; r++) begin
            int pos = 0;
            wr(2'd2, 32'(r));
            wr(2'd0, 32'd0);
            for (int s = 0; s < 6; s++) begin
                strobe(steps[s]);
                pos += steps[s];
                chk("R9", $sformatf("rate %0d at %0d", r, pos),
                    {31'd0, pin_n}, {31'd0, tap(r, pos)});
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_count();
        t_wrap();
        t_alarm();
        t_alarm_off();
        t_zero_reload();
        t_stop();
        t_wave();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule